// File: doc/BRIEF.md
# Three-Wire Write-Only Control Port

This block receives 16-bit control words over a three-wire serial link made of a serial clock, a serial data line and a latch line. It samples all three lines with a faster system clock, shifts data in most significant bit first on each rising edge of the serial clock, and decodes the word into control registers only when the latch line rises. Nothing can be read back through the link.

One word carries every global setting plus a channel-select bit. The channel-select bit routes the 10-bit volume field to either the left or the right volume request register. The other fields are: a 2-bit input-format select, a soft power-down bit, a de-emphasis enable and a mute bit. Each output register has a one-cycle update strobe, so that downstream logic such as a volume ramp can register the new request in the system clock domain.

The serial clock may run in bursts or continuously. If more than 16 bits arrive before a latch edge, only the last 16 are used. A latch edge that follows fewer than 16 bits is discarded.

Top module: `scp_top`

## Requirements
- R1: Serial data is sampled on each rising edge of the serial clock and shifted in most significant bit first, so the bit sent first lands in word bit 15.
- R2: Outputs change only in response to a rising edge of the latch line; shifting bits without a latch edge leaves every output unchanged.
- R3: A latch rising edge that follows fewer than 16 sampled bits is ignored. Every latch rising edge restarts the bit count at zero.
- R4: When more than 16 bits arrive before a latch rising edge, the word decoded is made of the last 16 bits.
- R5: Field positions: bits 15:14 give the input-format select, bit 13 soft power-down, bit 12 de-emphasis enable (1 = on) and bit 11 mute (1 = muted, 0 = normal).
- R6: Bit 10 selects the channel (0 = left, 1 = right). Bits 9:0 are written to the selected channel's volume request, and the other channel's volume is left unchanged.
- R7: After hardware reset, both volumes are 0x3FF, and mute, de-emphasis, power-down and format are all 0. No strobe is active.
- R8: An accepted word with bit 13 set drives power-down to 1 and returns both volumes to 0x3FF and mute, de-emphasis and format to 0, whatever its other bits hold. The next accepted word with bit 13 clear releases power-down.
- R9: Every accepted word pulses the format, mute, de-emphasis and power-down strobes for exactly one cycle. It also pulses the strobe of the volume it writes, and both volume strobes for a power-down word. A value output changes only in a cycle where its strobe is high.
- R10: Words are accepted the same way whether the serial clock is gated between words or keeps toggling while the latch is high and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_lat_i | input | 1 | Latch; rising edge commits the word |
| vol_left_o | output | 10 | Left volume request |
| vol_left_upd_o | output | 1 | Left volume update strobe |
| vol_right_o | output | 10 | Right volume request |
| vol_right_upd_o | output | 1 | Right volume update strobe |
| mute_o | output | 1 | Mute request |
| mute_upd_o | output | 1 | Mute update strobe |
| deemph_o | output | 1 | De-emphasis enable |
| deemph_upd_o | output | 1 | De-emphasis update strobe |
| pwrdn_o | output | 1 | Soft power-down request |
| pwrdn_upd_o | output | 1 | Power-down update strobe |
| fmt_o | output | 2 | Input-format select |
| fmt_upd_o | output | 1 | Format update strobe |

## Verification
Volume values are swept across the whole 10-bit range in a fixed stride for both channel-select values. The upper field bits are derived from the volume, so every field combination appears and any swapped, shifted or misrouted bit shows up as a wrong value on one specific output. Short words, over-long words and words sent with a free-running serial clock separate correct bit counting from off-by-one or non-restarting counters. Power-down words carrying non-default field bits separate true defaulting from a plain field copy. The strobe pulses are counted and compared against the expected count for each word.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int FMT_W  = 2;
  localparam int VOL_W  = 10;
  localparam int WORD_W = FMT_W + 4 + VOL_W;
  localparam logic [VOL_W-1:0] VOL_DEFAULT = '1;

  // Word layout, MSB first: format, power-down, de-emphasis, mute, channel, volume
  typedef struct packed {
    logic [FMT_W-1:0] fmt;
    logic             pwrdn;
    logic             deemph;
    logic             mute;
    logic             chan;
    logic [VOL_W-1:0] vol;
  } ctl_word_t;

  typedef struct packed {
    logic [VOL_W-1:0] vol_l;
    logic [VOL_W-1:0] vol_r;
    logic             mute;
    logic             deemph;
    logic             pwrdn;
    logic [FMT_W-1:0] fmt;
  } ctl_state_t;

  typedef struct packed {
    logic vol_l;
    logic vol_r;
    logic mute;
    logic deemph;
    logic pwrdn;
    logic fmt;
  } ctl_upd_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o
);
  localparam int PIPE_W = STAGES + 1;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [PIPE_W-1:0] pipe_q;
      logic [PIPE_W-1:0] pipe_d;

      always_comb begin
        pipe_d = {pipe_q[PIPE_W-2:0], async_i[g]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q <= '0;
        end else begin
          pipe_q <= pipe_d;
        end
      end

      // Stage STAGES-1 is the synchronized level; stage STAGES holds its previous value
      assign level_o[g] = pipe_q[STAGES-1];
      assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  input  logic              restart,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    shift_d = shift_q;
    if (shift_en) begin
      shift_d = {shift_q[WORD_W-2:0], bit_i};
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (shift_en && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  assign word_o = shift_q;
  assign full_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word_i,
  output ctl_state_t        state_o,
  output ctl_upd_t          upd_o
);
  ctl_state_t state_q, state_d;
  ctl_upd_t   upd_q, upd_d;
  ctl_word_t  w;
  ctl_state_t dflt;

  always_comb begin
    dflt.vol_l  = VOL_DEFAULT;
    dflt.vol_r  = VOL_DEFAULT;
    dflt.mute   = 1'b0;
    dflt.deemph = 1'b0;
    dflt.pwrdn  = 1'b0;
    dflt.fmt    = '0;
  end

  assign w = ctl_word_t'(word_i);

  always_comb begin
    state_d = state_q;
    upd_d   = '0;
    if (commit) begin
      upd_d.mute   = 1'b1;
      upd_d.deemph = 1'b1;
      upd_d.pwrdn  = 1'b1;
      upd_d.fmt    = 1'b1;
      if (w.pwrdn) begin
        state_d       = dflt;
        state_d.pwrdn = 1'b1;
        upd_d.vol_l   = 1'b1;
        upd_d.vol_r   = 1'b1;
      end else begin
        state_d.fmt    = w.fmt;
        state_d.pwrdn  = 1'b0;
        state_d.deemph = w.deemph;
        state_d.mute   = w.mute;
        if (w.chan) begin
          state_d.vol_r = w.vol;
          upd_d.vol_r   = 1'b1;
        end else begin
          state_d.vol_l = w.vol;
          upd_d.vol_l   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= dflt;
      upd_q   <= '0;
    end else begin
      state_q <= state_d;
      upd_q   <= upd_d;
    end
  end

  assign state_o = state_q;
  assign upd_o   = upd_q;
endmodule

// File: rtl/scp_top.sv
module scp_top
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_lat_i,
  output logic [VOL_W-1:0] vol_left_o,
  output logic             vol_left_upd_o,
  output logic [VOL_W-1:0] vol_right_o,
  output logic             vol_right_upd_o,
  output logic             mute_o,
  output logic             mute_upd_o,
  output logic             deemph_o,
  output logic             deemph_upd_o,
  output logic             pwrdn_o,
  output logic             pwrdn_upd_o,
  output logic [FMT_W-1:0] fmt_o,
  output logic             fmt_upd_o
);
  localparam int LINES = 3;
  localparam int L_CLK = 0;
  localparam int L_DAT = 1;
  localparam int L_LAT = 2;

  // Reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LINES-1:0] raw, lvl, rise;
  assign raw = {ser_lat_i, ser_dat_i, ser_clk_i};

  scp_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (raw),
    .level_o (lvl),
    .rise_o  (rise)
  );

  logic [WORD_W-1:0] word;
  logic              full;
  logic              commit;

  scp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (rise[L_CLK]),
    .bit_i    (lvl[L_DAT]),
    .restart  (rise[L_LAT]),
    .word_o   (word),
    .full_o   (full)
  );

  assign commit = rise[L_LAT] & full;

  ctl_state_t st;
  ctl_upd_t   up;

  scp_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .commit  (commit),
    .word_i  (word),
    .state_o (st),
    .upd_o   (up)
  );

  assign vol_left_o      = st.vol_l;
  assign vol_right_o     = st.vol_r;
  assign mute_o          = st.mute;
  assign deemph_o        = st.deemph;
  assign pwrdn_o         = st.pwrdn;
  assign fmt_o           = st.fmt;
  assign vol_left_upd_o  = up.vol_l;
  assign vol_right_upd_o = up.vol_r;
  assign mute_upd_o      = up.mute;
  assign deemph_upd_o    = up.deemph;
  assign pwrdn_upd_o     = up.pwrdn;
  assign fmt_upd_o       = up.fmt;
endmodule

// File: rtl/scp_checker.sv
module scp_checker
  import scp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [VOL_W-1:0] vol_left_o,
  input logic             vol_left_upd_o,
  input logic [VOL_W-1:0] vol_right_o,
  input logic             vol_right_upd_o,
  input logic             mute_o,
  input logic             mute_upd_o,
  input logic             deemph_o,
  input logic             deemph_upd_o,
  input logic             pwrdn_o,
  input logic             pwrdn_upd_o,
  input logic [FMT_W-1:0] fmt_o,
  input logic             fmt_upd_o
);
  assert_vol_left_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_left_upd_o |-> $stable(vol_left_o));
  assert_vol_right_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_right_upd_o |-> $stable(vol_right_o));
  assert_mute_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_upd_o |-> $stable(mute_o));
  assert_fmt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_upd_o |-> $stable(fmt_o));
  assert_pwrdn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_upd_o |-> $stable(pwrdn_o));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_upd_o |=> !pwrdn_upd_o);
  assert_vol_strobe_with_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_left_upd_o || vol_right_upd_o) |-> (fmt_upd_o && mute_upd_o && deemph_upd_o));
  assert_pwrdn_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_o |-> (vol_left_o == VOL_DEFAULT && vol_right_o == VOL_DEFAULT &&
                 !mute_o && !deemph_o && fmt_o == '0));
endmodule

bind scp_top scp_checker u_scp_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .vol_left_o      (vol_left_o),
  .vol_left_upd_o  (vol_left_upd_o),
  .vol_right_o     (vol_right_o),
  .vol_right_upd_o (vol_right_upd_o),
  .mute_o          (mute_o),
  .mute_upd_o      (mute_upd_o),
  .deemph_o        (deemph_o),
  .deemph_upd_o    (deemph_upd_o),
  .pwrdn_o         (pwrdn_o),
  .pwrdn_upd_o     (pwrdn_upd_o),
  .fmt_o           (fmt_o),
  .fmt_upd_o       (fmt_upd_o)
);

// File: tb/scp_top_bench.sv
module scp_top_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sclk, sdat, slat;
  logic [9:0] vol_left_o, vol_right_o;
  logic [1:0] fmt_o;
  logic vol_left_upd_o, vol_right_upd_o, mute_o, mute_upd_o, deemph_o, deemph_upd_o;
  logic pwrdn_o, pwrdn_upd_o, fmt_upd_o;

  scp_top u_scp_top (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_lat_i(slat),
    .vol_left_o(vol_left_o), .vol_left_upd_o(vol_left_upd_o),
    .vol_right_o(vol_right_o), .vol_right_upd_o(vol_right_upd_o),
    .mute_o(mute_o), .mute_upd_o(mute_upd_o),
    .deemph_o(deemph_o), .deemph_upd_o(deemph_upd_o),
    .pwrdn_o(pwrdn_o), .pwrdn_upd_o(pwrdn_upd_o),
    .fmt_o(fmt_o), .fmt_upd_o(fmt_upd_o)
  );

  int n_pass = 0, n_fail = 0;
  int n_vl = 0, n_vr = 0, n_mu = 0, n_dm = 0, n_pd = 0, n_fm = 0;
  int s_vl, s_vr, s_mu, s_dm, s_pd, s_fm;
  int d_vl, d_vr, d_oth;
  logic [9:0] e_vl, e_vr;
  logic [1:0] e_fmt;
  logic e_mute, e_dm, e_pd;

  always @(posedge clk) begin
    if (vol_left_upd_o)  n_vl++;
    if (vol_right_upd_o) n_vr++;
    if (mute_upd_o)      n_mu++;
    if (deemph_upd_o)    n_dm++;
    if (pwrdn_upd_o)     n_pd++;
    if (fmt_upd_o)       n_fm++;
  end

  task automatic chk_eq(string tag, int act, int exp);
    if (act == exp) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i]; sclk = 1'b0; wclk(3);
      sclk = 1'b1; wclk(3);
    end
    sclk = 1'b0; wclk(3);
  endtask

  task automatic pulse_latch();
    slat = 1'b1; wclk(4);
    slat = 1'b0; wclk(8);
  endtask

  task automatic snap();
    s_vl = n_vl; s_vr = n_vr; s_mu = n_mu; s_dm = n_dm; s_pd = n_pd; s_fm = n_fm;
    d_vl = 0; d_vr = 0; d_oth = 0;
  endtask

  task automatic model(logic [15:0] w);
    d_oth = 1;
    if (w[13]) begin
      e_vl = 10'h3FF; e_vr = 10'h3FF; e_mute = 0; e_dm = 0; e_fmt = 0; e_pd = 1;
      d_vl = 1; d_vr = 1;
    end else begin
      e_fmt = w[15:14]; e_pd = 0; e_dm = w[12]; e_mute = w[11];
      if (w[10]) begin e_vr = w[9:0]; d_vr = 1; end
      else begin e_vl = w[9:0]; d_vl = 1; end
    end
  endtask

  task automatic check_all(string tv, string ts);
    chk_eq(tv, int'(vol_left_o), int'(e_vl));
    chk_eq(tv, int'(vol_right_o), int'(e_vr));
    chk_eq("R5 mute", int'(mute_o), int'(e_mute));
    chk_eq("R5 deemph", int'(deemph_o), int'(e_dm));
    chk_eq("R5 pwrdn", int'(pwrdn_o), int'(e_pd));
    chk_eq("R5 fmt", int'(fmt_o), int'(e_fmt));
    chk_eq(ts, n_vl - s_vl, d_vl);
    chk_eq(ts, n_vr - s_vr, d_vr);
    chk_eq(ts, n_mu - s_mu, d_oth);
    chk_eq(ts, n_dm - s_dm, d_oth);
    chk_eq(ts, n_pd - s_pd, d_oth);
    chk_eq(ts, n_fm - s_fm, d_oth);
  endtask

  task automatic write_word(logic [15:0] w, string tv);
    snap();
    send_bits({16'h0, w}, 16);
    pulse_latch();
    model(w);
    check_all(tv, "R9 strobes");
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; slat = 1'b0;
    e_vl = 10'h3FF; e_vr = 10'h3FF; e_mute = 0; e_dm = 0; e_pd = 0; e_fmt = 0;
    wclk(4);
    rst_n = 1'b1;
    wclk(6);
    // R7: reset defaults and quiet strobes
    snap();
    check_all("R7 reset vol", "R7 reset strobes");

    // R1 R6: volume sweep on both channels, upper fields derived from the value
    for (int v = 0; v < 1024; v += 7) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [9:0] vv;
        vv = v[9:0];
        write_word({vv[1:0], 1'b0, vv[2], vv[3], ch[0], vv}, "R1 R6 vol");
      end
    end

    // R2: full word shifted but no latch yet -> nothing changes
    snap();
    send_bits({16'h0, 16'b10_0_1_1_0_0001010101}, 16);
    check_all("R2 vol", "R2 strobes");
    pulse_latch();
    model(16'b10_0_1_1_0_0001010101);
    check_all("R2 vol", "R9 strobes");

    // R3: 15 bits then latch ignored; count restarts so 10+10 split ignored too
    snap();
    send_bits({16'h0, 16'h7123}, 15);
    pulse_latch();
    check_all("R3 vol", "R3 strobes");
    snap();
    send_bits(32'h155, 10); pulse_latch();
    send_bits(32'h2AA, 10); pulse_latch();
    check_all("R3 vol", "R3 strobes");
    write_word(16'h0412, "R3 vol");

    // R4: 19 bits, only the last 16 count
    snap();
    send_bits({13'h0, 3'b111, 16'b01_0_0_1_1_1100110011}, 19);
    pulse_latch();
    model(16'b01_0_0_1_1_1100110011);
    check_all("R4 vol", "R4 strobes");

    // R8: power-down word with non-default field bits
    write_word(16'b11_1_1_1_0_0000000001, "R8 vol");
    chk_eq("R8 pwrdn", int'(pwrdn_o), 1);
    write_word(16'b01_0_1_0_1_0101010101, "R8 release");
    chk_eq("R8 release", int'(pwrdn_o), 0);

    // R10: serial clock keeps toggling through and after the latch
    snap();
    send_bits({16'h0, 16'b10_0_0_1_0_0011110000}, 16);
    slat = 1'b1; wclk(3);
    for (int k = 0; k < 3; k++) begin
      sdat = 1'b1; sclk = 1'b1; wclk(3);
      sclk = 1'b0; wclk(3);
      if (k == 1) slat = 1'b0;
    end
    wclk(8);
    model(16'b10_0_0_1_0_0011110000);
    check_all("R10 vol", "R10 strobes");
    write_word(16'b00_0_1_0_1_1111000011, "R10 R4 vol");

    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule